// File: doc/BRIEF.md
# Key-Guarded Countdown Watchdog

This block is a watchdog timer whose settings sit behind a byte-wide index/data register pair. After reset the settings space is closed. Two back-to-back writes of the key byte 0x87 to the index port open it, and the lock byte 0xAA written to the index port closes it again. While it is open, an index write picks the register that the data port reads and writes. A page register must hold 0x08 before the watchdog registers become visible.

The watchdog page holds four registers. The first has an enable bit. The second picks whether the countdown runs in seconds or in minutes. The third is an 8-bit countdown that can be read and written. The fourth selects whether keyboard or mouse activity reloads the timer. A prescaler divides the clock down to seconds, and a second divider turns seconds into minutes. When the countdown runs out, the block raises a reset request for one cycle. The bus decode and the interrupt sources are outside the block. They reach it as single-cycle strobes.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the space is locked, every register (page 0x07, enable 0x30, unit 0xF5, count 0xF6, reload control 0xF7) is 0x00, `reset_req` is low, and `rd_data` reads 0xFF.
- R2: The space opens only after two index writes of 0x87 with no other index write between them. Any other index byte in the middle returns the block to locked. Data writes made while the space is locked change no register.
- R3: While the space is open, an index write of 0xAA locks it. That byte is not taken as an index.
- R4: `rd_data` shows 0xFF in three cases: the space is locked; the selected index is not 0x07 and the page is not 0x08; the selected index is not one of 0x07, 0x30, 0xF5, 0xF6, 0xF7.
- R5: Index 0x07 is the page register and can be read and written whenever the space is open. Only page value 0x08 makes the watchdog registers visible. Data writes to them are ignored on any other page.
- R6: All eight bits of registers 0x30, 0xF5 and 0xF7 are stored and read back unchanged. Only bit 0 of 0x30, bit 3 of 0xF5 and bits 6/7 of 0xF7 have any effect.
- R7: A data write to 0xF6 loads both the live count and the reload value. It also restarts the prescaler. Reading 0xF6 returns the live count.
- R8: When 0x30 bit 0 is 1, 0xF5 bit 3 is 0 and the count is nonzero, the count drops by one every TICKS_PER_SEC clocks after a load.
- R9: When 0xF5 bit 3 is 1, the count drops by one every TICKS_PER_SEC*SECS_PER_MIN clocks.
- R10: The clock edge that takes the count from 1 to 0 also raises `reset_req` for exactly one cycle. The count then stays at 0 and no further request follows.
- R11: A `kbd_evt` strobe reloads the count from the last value written to 0xF6 when 0xF7 bit 6 is 1. A `mouse_evt` strobe does the same when 0xF7 bit 7 is 1. A strobe whose bit is clear has no effect.
- R12: While the enable bit is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Strobe: write `wr_byte` to the index port |
| data_wr | input | 1 | Strobe: write `wr_byte` to the data port |
| wr_byte | input | 8 | Byte written on either port |
| kbd_evt | input | 1 | Keyboard activity strobe |
| mouse_evt | input | 1 | Mouse activity strobe |
| rd_data | output | 8 | Data port read value for the current index |
| reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest state to reach from the ports is a running countdown while reload sources are selectively armed. That needs a full open sequence, a page switch and several register writes, all while the prescaler keeps advancing. The stimulus reaches it with short scripted port sequences. A behavioural model tracks every clock, so reads and expiry pulses are checked even when they land in the middle of those sequences. Broken keys (0x87, another byte, 0x87) and writes on the wrong page are also driven, and their effect is read back once the space is properly opened.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam logic [7:0] KEY_OPEN   = 8'h87;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] IX_PAGE    = 8'h07;
    localparam logic [7:0] PAGE_WDOG  = 8'h08;
    localparam logic [7:0] IX_ENABLE  = 8'h30;
    localparam logic [7:0] IX_UNIT    = 8'hF5;
    localparam logic [7:0] IX_COUNT   = 8'hF6;
    localparam logic [7:0] IX_RELOAD  = 8'hF7;
    localparam logic [7:0] IDLE_READ  = 8'hFF;

    typedef enum logic [1:0] {
        KS_SHUT = 2'd0,
        KS_HALF = 2'd1,
        KS_OPEN = 2'd2
    } key_state_e;

    typedef struct packed {
        logic [7:0] enable;
        logic [7:0] unit;
        logic [7:0] reload_ctl;
    } wd_cfg_t;

    function automatic logic cfg_on(input wd_cfg_t c);
        return c.enable[0];
    endfunction

    function automatic logic cfg_minutes(input wd_cfg_t c);
        return c.unit[3];
    endfunction

endpackage

// File: rtl/keyed_wdog_key.sv
module keyed_wdog_key
    import keyed_wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wr_byte,
    output logic       open_o,
    output logic [7:0] index_o
);

    key_state_e state_q;
    logic [7:0] index_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_SHUT;
            index_q <= 8'h00;
        end else if (idx_wr) begin
            unique case (state_q)
                KS_SHUT: state_q <= (wr_byte == KEY_OPEN) ? KS_HALF : KS_SHUT;
                KS_HALF: state_q <= (wr_byte == KEY_OPEN) ? KS_OPEN : KS_SHUT;
                KS_OPEN: begin
                    if (wr_byte == KEY_CLOSE) state_q <= KS_SHUT;
                    else                      index_q <= wr_byte;
                end
                default: state_q <= KS_SHUT;
            endcase
        end
    end

    assign open_o  = (state_q == KS_OPEN);
    assign index_o = index_q;

    // R3: lock byte always closes an open space
    assert_close_key_R3: assert property (@(posedge clk) disable iff (rst)
        (open_o && idx_wr && wr_byte == KEY_CLOSE) |=> !open_o);

    // R2: the space never opens from the fully locked state in one write
    assert_two_keys_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == KS_SHUT) |=> !open_o);

endmodule

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       open_i,
    input  logic [7:0] index_i,
    input  logic       data_wr,
    input  logic [7:0] wr_byte,
    input  logic [7:0] live_count_i,
    output wd_cfg_t    cfg_o,
    output logic       count_load_o,
    output logic [7:0] reload_val_o,
    output logic [7:0] rd_data_o
);

    logic [7:0] page_q;
    wd_cfg_t    cfg_q;
    logic [7:0] reload_q;
    logic       page_ok;
    logic       wr_ok;

    assign page_ok = (page_q == PAGE_WDOG);
    assign wr_ok   = open_i && data_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q   <= 8'h00;
            cfg_q    <= '0;
            reload_q <= 8'h00;
        end else if (wr_ok) begin
            if (index_i == IX_PAGE) begin
                page_q <= wr_byte;
            end else if (page_ok) begin
                case (index_i)
                    IX_ENABLE: cfg_q.enable     <= wr_byte;
                    IX_UNIT:   cfg_q.unit       <= wr_byte;
                    IX_RELOAD: cfg_q.reload_ctl <= wr_byte;
                    IX_COUNT:  reload_q         <= wr_byte;
                    default:   ;
                endcase
            end
        end
    end

    assign count_load_o = wr_ok && page_ok && (index_i == IX_COUNT);
    assign reload_val_o = reload_q;
    assign cfg_o        = cfg_q;

    always_comb begin
        rd_data_o = IDLE_READ;
        if (open_i) begin
            if (index_i == IX_PAGE) begin
                rd_data_o = page_q;
            end else if (page_ok) begin
                case (index_i)
                    IX_ENABLE: rd_data_o = cfg_q.enable;
                    IX_UNIT:   rd_data_o = cfg_q.unit;
                    IX_COUNT:  rd_data_o = live_count_i;
                    IX_RELOAD: rd_data_o = cfg_q.reload_ctl;
                    default:   rd_data_o = IDLE_READ;
                endcase
            end
        end
    end

    // R2: data writes while locked leave every register untouched
    assert_locked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!open_i && data_wr) |=> ($stable(cfg_q) && $stable(page_q) && $stable(reload_q)));

    // R5: watchdog registers do not move while another page is selected
    assert_page_guard_R5: assert property (@(posedge clk) disable iff (rst)
        (!page_ok && index_i != IX_PAGE) |=> $stable(cfg_q));

endmodule

// File: rtl/keyed_wdog_timer.sv
module keyed_wdog_timer #(
    parameter int unsigned TICKS_PER_SEC = 1000000,
    parameter int unsigned SECS_PER_MIN  = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en_i,
    input  logic       minutes_i,
    input  logic       reload_i,
    input  logic [7:0] reload_val_i,
    output logic [7:0] count_o,
    output logic       expire_o
);

    localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int unsigned MW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);
    localparam logic [MW-1:0] MIN_LAST = MW'(SECS_PER_MIN - 1);

    logic [PW-1:0] pre_q;
    logic [MW-1:0] sec_q;
    logic [7:0]    count_q;
    logic          exp_q;
    logic          running, sec_tick, min_tick, unit_tick;

    assign running   = run_en_i && (count_q != 8'd0);
    assign sec_tick  = (pre_q == PRE_LAST);
    assign min_tick  = sec_tick && (sec_q == MIN_LAST);
    assign unit_tick = minutes_i ? min_tick : sec_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            sec_q   <= '0;
            count_q <= 8'd0;
            exp_q   <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (reload_i) begin
                count_q <= reload_val_i;
                pre_q   <= '0;
                sec_q   <= '0;
            end else if (running) begin
                pre_q <= sec_tick ? '0 : pre_q + PW'(1);
                if (sec_tick) sec_q <= min_tick ? '0 : sec_q + MW'(1);
                if (unit_tick) begin
                    count_q <= count_q - 8'd1;
                    exp_q   <= (count_q == 8'd1);
                end
            end else begin
                pre_q <= '0;
                sec_q <= '0;
            end
        end
    end

    assign count_o  = count_q;
    assign expire_o = exp_q;

    // R10: the request lasts one cycle
    assert_one_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);

    // R10: a request only coincides with an exhausted count
    assert_zero_on_req_R10: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> (count_o == 8'd0));

    // R8: without a reload the count only holds or steps down by one
    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        !reload_i |=> (count_o == $past(count_o) || count_o == $past(count_o) - 8'd1));

    // R12: a disabled timer holds its count
    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!run_en_i && !reload_i) |=> $stable(count_o));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1000000,
    parameter int unsigned SECS_PER_MIN  = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wr_byte,
    input  logic       kbd_evt,
    input  logic       mouse_evt,
    output logic [7:0] rd_data,
    output logic       reset_req
);

    logic       open_w;
    logic [7:0] index_w;
    wd_cfg_t    cfg_w;
    logic       load_w;
    logic [7:0] reload_val_w;
    logic [7:0] count_w;
    logic       evt_reload;
    logic       any_reload;
    logic [7:0] next_val;

    keyed_wdog_key u_key (
        .clk     (clk),
        .rst     (rst),
        .idx_wr  (idx_wr),
        .wr_byte (wr_byte),
        .open_o  (open_w),
        .index_o (index_w)
    );

    keyed_wdog_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .open_i       (open_w),
        .index_i      (index_w),
        .data_wr      (data_wr),
        .wr_byte      (wr_byte),
        .live_count_i (count_w),
        .cfg_o        (cfg_w),
        .count_load_o (load_w),
        .reload_val_o (reload_val_w),
        .rd_data_o    (rd_data)
    );

    assign evt_reload = (kbd_evt && cfg_w.reload_ctl[6]) || (mouse_evt && cfg_w.reload_ctl[7]);
    assign any_reload = load_w || evt_reload;
    assign next_val   = load_w ? wr_byte : reload_val_w;

    keyed_wdog_timer #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SECS_PER_MIN  (SECS_PER_MIN)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .run_en_i     (cfg_on(cfg_w)),
        .minutes_i    (cfg_minutes(cfg_w)),
        .reload_i     (any_reload),
        .reload_val_i (next_val),
        .count_o      (count_w),
        .expire_o     (reset_req)
    );

    // R4: a locked space reads back the idle value
    assert_locked_read_R4: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && wr_byte == KEY_CLOSE && open_w) |=> (rd_data == IDLE_READ));

    // R11: an armed keyboard event restores the reload value
    assert_kbd_reload_R11: assert property (@(posedge clk) disable iff (rst)
        (kbd_evt && cfg_w.reload_ctl[6] && !load_w) |=> (count_w == $past(reload_val_w)));

endmodule

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;

    localparam int TPS = 4;
    localparam int SPM = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       kbd_evt = 1'b0;
    logic       mouse_evt = 1'b0;
    logic [7:0] rd_data;
    logic       reset_req;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    keyed_wdog #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM)) uut (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .data_wr(data_wr), .wr_byte(wr_byte),
        .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .rd_data(rd_data), .reset_req(reset_req)
    );

    always #4 clk = ~clk;   // 125 MHz

    // behavioural reference model
    int m_state, m_idx, m_page, m_en, m_unit, m_rc, m_tmo, m_cnt, m_pre, m_secs, m_req;

    function automatic int model_read();
        if (m_state != 2) return 255;
        if (m_idx == 7) return m_page;
        if (m_page != 8) return 255;
        case (m_idx)
            8'h30: return m_en;
            8'hF5: return m_unit;
            8'hF6: return m_cnt;
            8'hF7: return m_rc;
            default: return 255;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_idx = 0; m_page = 0; m_en = 0; m_unit = 0; m_rc = 0;
            m_tmo = 0; m_cnt = 0; m_pre = 0; m_secs = 0; m_req = 0;
        end else begin
            bit opened, wd_ok, cnt_wr, reload, tick_s, tick_m, unit_hit;
            int d, val;
            d = wr_byte;
            opened = (m_state == 2);
            wd_ok = opened && data_wr && (m_page == 8) && (m_idx != 7);
            cnt_wr = wd_ok && (m_idx == 8'hF6);
            reload = cnt_wr || (kbd_evt && m_rc[6]) || (mouse_evt && m_rc[7]);
            val = cnt_wr ? d : m_tmo;
            m_req = 0;
            if (reload) begin
                m_cnt = val; m_pre = 0; m_secs = 0;
            end else if (m_en[0] && m_cnt != 0) begin
                tick_s = (m_pre == TPS - 1);
                m_pre = tick_s ? 0 : m_pre + 1;
                tick_m = 0;
                if (tick_s) begin
                    tick_m = (m_secs == SPM - 1);
                    m_secs = tick_m ? 0 : m_secs + 1;
                end
                unit_hit = m_unit[3] ? tick_m : tick_s;
                if (unit_hit) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_req = 1;
                end
            end else begin
                m_pre = 0; m_secs = 0;
            end
            if (opened && data_wr) begin
                if (m_idx == 7) m_page = d;
                else if (wd_ok) begin
                    case (m_idx)
                        8'h30: m_en = d;
                        8'hF5: m_unit = d;
                        8'hF7: m_rc = d;
                        8'hF6: m_tmo = d;
                        default: ;
                    endcase
                end
            end
            if (idx_wr) begin
                case (m_state)
                    0: m_state = (d == 8'h87) ? 1 : 0;
                    1: m_state = (d == 8'h87) ? 2 : 0;
                    default: if (d == 8'hAA) m_state = 0; else m_idx = d;
                endcase
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        cycles++;
        #2;
        if (!rst) begin
            check("R4 rd_data vs model", rd_data, model_read());
            check("R10 reset_req vs model", reset_req, m_req);
        end
    end

    task automatic idx_w(input logic [7:0] b);
        @(negedge clk); wr_byte = b; idx_wr = 1'b1;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic dat_w(input logic [7:0] b);
        @(negedge clk); wr_byte = b; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic put(input logic [7:0] ix, input logic [7:0] b);
        idx_w(ix); dat_w(b);
    endtask

    task automatic unlock();
        idx_w(8'h87); idx_w(8'h87);
    endtask

    task automatic to_expiry(output int n);
        n = 0;
        while (n < 200) begin
            @(posedge clk); #2; n++;
            if (reset_req) break;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int n, v, pulses;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset read", rd_data, 8'hFF);
        check("R1 reset_req low", reset_req, 0);

        // locked writes ignored, broken key keeps locked
        dat_w(8'h5A);
        idx_w(8'h87); idx_w(8'h12); idx_w(8'h87);
        check("R2 broken key stays locked", rd_data, 8'hFF);
        idx_w(8'h87);
        idx_w(8'h07);
        check("R5 page reads zero", rd_data, 8'h00);
        idx_w(8'h30);
        check("R4 wrong page reads FF", rd_data, 8'hFF);
        dat_w(8'h5A);
        put(8'h07, 8'h08);
        idx_w(8'h30);
        check("R5 wrong-page write ignored", rd_data, 8'h00);
        dat_w(8'hA4);
        check("R6 enable reg all bits", rd_data, 8'hA4);
        put(8'hF5, 8'h71);
        check("R6 unit reg all bits", rd_data, 8'h71);
        put(8'hF7, 8'h3E);
        check("R6 reload ctl all bits", rd_data, 8'h3E);
        idx_w(8'h44);
        check("R4 unmapped index", rd_data, 8'hFF);
        idx_w(8'hF7);
        idx_w(8'hAA);
        check("R3 relock reads FF", rd_data, 8'hFF);
        dat_w(8'h00);
        unlock();
        check("R3 AA not taken as index", rd_data, 8'h3E);
        check("R2 locked write ignored", rd_data, 8'h3E);

        // seconds countdown
        put(8'hF5, 8'h71);
        put(8'h30, 8'hA5);
        put(8'hF6, 8'h03);
        check("R7 count write reads back", rd_data, 8'h03);
        to_expiry(n);
        check("R8 seconds expiry cycles", n, 3 * TPS);
        @(negedge clk);
        check("R10 count stays zero", rd_data, 8'h00);
        pulses = 0;
        repeat (30) begin @(posedge clk); #2; if (reset_req) pulses++; end
        check("R10 no second request", pulses, 0);

        // minute countdown
        put(8'hF5, 8'h79);
        put(8'hF6, 8'h02);
        to_expiry(n);
        check("R9 minutes expiry cycles", n, 2 * TPS * SPM);
        put(8'hF5, 8'h71);

        // event reloads
        put(8'hF7, 8'h7E);
        put(8'hF6, 8'h05);
        repeat (6) @(negedge clk);
        @(negedge clk); kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        check("R11 keyboard reload", rd_data, 8'h05);
        repeat (8) @(negedge clk);
        @(negedge clk); mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
        check("R11 unarmed mouse ignored", rd_data, 8'h03);
        put(8'hF7, 8'hBE);
        idx_w(8'hF6);
        @(negedge clk); mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
        check("R11 mouse reload", rd_data, 8'h05);

        // disable holds count
        put(8'h30, 8'hA4);
        idx_w(8'hF6);
        v = rd_data;
        repeat (30) @(negedge clk);
        check("R12 disabled count holds", rd_data, v);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule